// File: doc/BRIEF.md
# Paged EEPROM Write Load Controller

This block models the write path of a byte-wide paged nonvolatile memory that is driven through an SRAM-style strobe port. The port has three active-low strobes (chip select, read enable, write strobe), a 17-bit address and an 8-bit data bus. The block first brings the strobes into its own clock domain. It merges chip select and write strobe into one write event and filters out short glitches. It captures the address and data at the edges the strobe protocol defines.

The first accepted byte after an idle period opens a load period and fixes the page, which is address bits 16..7. Later bytes on that page go into a 128-byte page buffer and set a per-byte loaded mask. A byte that addresses a different page is dropped, and a sticky error flag records it. The load period closes on its own once no byte has arrived for a set number of cycles. A programming phase of fixed length follows, with `busy` high. At the end of that phase only the loaded bytes are written into a behavioural array.

The array holds the low `STORE_W` address bits, so upper page bits alias. It is read combinationally on `dout`. For a set number of cycles after reset, all write events are discarded. Every time limit is a parameter counted in clock cycles.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, `busy` and `page_err` are 0 and every array byte reads 0xFF.
- R2: A write phase exists only while `cs_n` and `we_n` are both low and `re_n` is high. A write is blocked if `re_n` is held low. If `re_n` falls before either strobe rises, that phase produces no write.
- R3: The address is taken when the later of the two strobes falls. The data is taken when the earlier of the two strobes rises. Address or data changes outside those moments have no effect.
- R4: A write phase shorter than `GLITCH_CYC` synchronised cycles is discarded. A phase of exactly `GLITCH_CYC` cycles is accepted.
- R5: Write events in the first `POR_CYC` cycles after reset are discarded.
- R6: Address bits 16..7 select the page and bits 6..0 select the byte. The first accepted byte of a load period fixes the page.
- R7: During a load period, a byte on a different page is dropped and `page_err` goes to 1. `page_err` stays 1 until the first byte of the next load period clears it.
- R8: The load period ends `GAP_CYC` cycles after the last accepted byte, and `busy` rises on the next cycle. A byte that arrives in the final cycle of the window is accepted and restarts the window.
- R9: `busy` stays high for exactly `PROG_CYC` cycles. When it falls, the array already holds the new bytes.
- R10: Bytes may be loaded in any order. A byte loaded twice keeps its last value. Bytes not loaded keep their old array contents.
- R11: Write events while `busy` is high are ignored. They neither alter the page buffer nor start a new load.
- R12: `dout` shows the array byte at `addr[STORE_W-1:0]` combinationally, so addresses that differ only in higher bits read the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select strobe, active low, asynchronous |
| re_n | input | 1 | Read enable, active low, asynchronous; low blocks writes |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | ADDR_W (17) | Byte address: page in 16..7, byte offset in 6..0 |
| din | input | 8 | Write data |
| dout | output | 8 | Array byte at the current address |
| busy | output | 1 | Programming phase in progress |
| page_err | output | 1 | Sticky flag: an off-page byte was dropped in this load period |

## Verification
The collision of interest is a byte arriving in the same cycle that the inter-byte window runs out. In that case the load must continue rather than close. The bench produces this by timing the release of a second byte to exactly `GAP_CYC` cycles after the first, and then again one cycle later. It judges the outcome from `busy` timing and from the array contents after programming. On time, both bytes must be programmed. One cycle late, the second byte falls into the programming phase and must be absent.

// File: rtl/pgwr_pkg.sv
// Package: shared types for the paged write controller.
// Assumes: nothing beyond standard SystemVerilog.
package pgwr_pkg;

    // Sequencer phase: idle, gathering bytes, or programming the array.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } pgwr_phase_e;

endpackage

// File: rtl/pgwr_strobe.sv
// Module: pgwr_strobe
// Brings the three asynchronous strobes into the clock domain and merges
// chip select and write strobe into one write phase. Emits a one-cycle event
// carrying the address taken at phase start and the data present at phase end.
// Assumes: addr is stable from two cycles before the later strobe fall until
// three cycles after it. din is stable around the earlier strobe rise for the
// same span.
module pgwr_strobe #(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int GLITCH_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              re_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_ev,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [DATA_W-1:0] ev_data
);
    localparam int HC_W = $clog2(GLITCH_CYC + 1);

    logic [2:0]        sy1, sy2;      // {re, we, cs} synchroniser stages
    logic              cs_s, we_s, re_s;
    logic              act, act_q, act_end;
    logic [HC_W-1:0]   hi_cnt;
    logic [ADDR_W-1:0] addr_q;

    assign cs_s = sy2[0];
    assign we_s = sy2[1];
    assign re_s = sy2[2];

    // Two-stage synchroniser for the strobes, idle state is all high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sy1 <= 3'b111;
            sy2 <= 3'b111;
        end else begin
            sy1 <= {re_n, we_n, cs_n};
            sy2 <= sy1;
        end
    end

    // Merged write phase and its end condition (re_n still high).
    always_comb begin
        act     = !cs_s && !we_s && re_s;
        act_end = act_q && !act && re_s;
    end

    // Phase history, saturating phase length and address taken at phase start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            hi_cnt <= '0;
            addr_q <= '0;
        end else begin
            act_q <= act;
            if (!act) begin
                hi_cnt <= '0;
            end else if (hi_cnt != HC_W'(GLITCH_CYC)) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
            if (act && !act_q) begin
                addr_q <= addr;
            end
        end
    end

    // Event only for phases that lasted the minimum width.
    always_comb begin
        wr_ev   = act_end && (hi_cnt >= HC_W'(GLITCH_CYC));
        ev_addr = addr_q;
        ev_data = din;
    end

endmodule

// File: rtl/pgwr_page_buf.sv
// Module: pgwr_page_buf
// Page buffer: holds one byte per offset plus a loaded mask, and latches the
// page of the first byte of a load period.
// Assumes: buf_start and buf_wr are never high together.
module pgwr_page_buf #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int OFF_W  = 7,
    parameter int SPG_W  = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 buf_start,
    input  logic                                 buf_wr,
    input  logic [ADDR_W-1:0]                    ev_addr,
    input  logic [DATA_W-1:0]                    ev_data,
    output logic                                 page_hit,
    output logic [SPG_W-1:0]                     store_page,
    output logic [(1<<OFF_W)-1:0]                vmask,
    output logic [(1<<OFF_W)-1:0][DATA_W-1:0]    pdata
);
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int PG_W       = ADDR_W - OFF_W;

    logic [PG_W-1:0]  page_q;
    logic [OFF_W-1:0] off;

    assign off = ev_addr[OFF_W-1:0];

    // Page match of the incoming byte and the array page used at commit.
    always_comb begin
        page_hit   = (ev_addr[ADDR_W-1:OFF_W] == page_q);
        store_page = page_q[SPG_W-1:0];
    end

    // Page latch and loaded mask: cleared to one bit at start, bits added later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            vmask  <= '0;
        end else if (buf_start) begin
            page_q <= ev_addr[ADDR_W-1:OFF_W];
            for (int i = 0; i < PAGE_BYTES; i++) begin
                vmask[i] <= (off == OFF_W'(i));
            end
        end else if (buf_wr) begin
            vmask[off] <= 1'b1;
        end
    end

    // Byte storage, no reset needed since the mask qualifies every slot.
    always_ff @(posedge clk) begin
        if (buf_start || buf_wr) begin
            pdata[off] <= ev_data;
        end
    end

endmodule

// File: rtl/pgwr_seq.sv
// Module: pgwr_seq
// Sequencer: power-up hold-off, load window timing and programming timing.
// One timer serves the gap window and the programming phase.
// Assumes: wr_ev is a single-cycle pulse.
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int GAP_CYC  = 64,
    parameter int PROG_CYC = 200,
    parameter int POR_CYC  = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ev,
    input  logic page_hit,
    output logic buf_start,
    output logic buf_wr,
    output logic commit,
    output logic busy,
    output logic page_err,
    output logic por_ok
);
    localparam int TMAX = (GAP_CYC > PROG_CYC) ? GAP_CYC : PROG_CYC;
    localparam int TM_W = $clog2(TMAX + 1);
    localparam int PO_W = $clog2(POR_CYC + 1);

    pgwr_phase_e     phase;
    logic [TM_W-1:0] tmr;
    logic [PO_W-1:0] por_cnt;
    logic            pg_miss;

    // Power-up hold-off counter, saturating at POR_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_cnt <= '0;
        end else if (por_cnt != PO_W'(POR_CYC)) begin
            por_cnt <= por_cnt + 1'b1;
        end
    end

    // Decode of buffer actions and end-of-programming strobe.
    always_comb begin
        por_ok    = (por_cnt == PO_W'(POR_CYC));
        buf_start = (phase == PH_IDLE) && wr_ev && por_ok;
        buf_wr    = (phase == PH_LOAD) && wr_ev && page_hit;
        pg_miss   = (phase == PH_LOAD) && wr_ev && !page_hit;
        commit    = (phase == PH_PROG) && (tmr == TM_W'(PROG_CYC - 1));
        busy      = (phase == PH_PROG);
    end

    // Phase transitions with the shared timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            tmr   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    tmr <= '0;
                    if (buf_start) phase <= PH_LOAD;
                end
                PH_LOAD: begin
                    if (buf_wr) begin
                        tmr <= '0;
                    end else if (tmr == TM_W'(GAP_CYC - 1)) begin
                        tmr   <= '0;
                        phase <= PH_PROG;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                PH_PROG: begin
                    if (commit) begin
                        tmr   <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: begin
                    tmr   <= '0;
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    // Sticky off-page flag, cleared when a new load period opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_err <= 1'b0;
        end else if (buf_start) begin
            page_err <= 1'b0;
        end else if (pg_miss) begin
            page_err <= 1'b1;
        end
    end

endmodule

// File: rtl/pgwr_ctrl.sv
// Module: pgwr_ctrl (top)
// Paged write controller: strobe front end, page buffer, sequencer and a
// behavioural array that receives the loaded bytes at commit.
// Assumes: the array keeps only the low STORE_W address bits.
module pgwr_ctrl #(
    parameter int ADDR_W     = 17,
    parameter int OFF_W      = 7,
    parameter int STORE_W    = 10,
    parameter int GAP_CYC    = 64,
    parameter int PROG_CYC   = 200,
    parameter int POR_CYC    = 40,
    parameter int GLITCH_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              re_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              busy,
    output logic              page_err
);
    localparam int DATA_W     = 8;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int SPG_W      = STORE_W - OFF_W;
    localparam int MEM_BYTES  = 1 << STORE_W;

    logic                                 wr_ev;
    logic [ADDR_W-1:0]                    ev_addr;
    logic [DATA_W-1:0]                    ev_data;
    logic                                 page_hit;
    logic                                 buf_start;
    logic                                 buf_wr;
    logic                                 commit;
    logic                                 por_ok;
    logic [SPG_W-1:0]                     store_page;
    logic [PAGE_BYTES-1:0]                vmask;
    logic [PAGE_BYTES-1:0][DATA_W-1:0]    pdata;
    logic [DATA_W-1:0]                    mem [MEM_BYTES];

    pgwr_strobe #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .GLITCH_CYC (GLITCH_CYC)
    ) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .re_n    (re_n),
        .we_n    (we_n),
        .addr    (addr),
        .din     (din),
        .wr_ev   (wr_ev),
        .ev_addr (ev_addr),
        .ev_data (ev_data)
    );

    pgwr_page_buf #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W),
        .SPG_W  (SPG_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_start  (buf_start),
        .buf_wr     (buf_wr),
        .ev_addr    (ev_addr),
        .ev_data    (ev_data),
        .page_hit   (page_hit),
        .store_page (store_page),
        .vmask      (vmask),
        .pdata      (pdata)
    );

    pgwr_seq #(
        .GAP_CYC  (GAP_CYC),
        .PROG_CYC (PROG_CYC),
        .POR_CYC  (POR_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ev     (wr_ev),
        .page_hit  (page_hit),
        .buf_start (buf_start),
        .buf_wr    (buf_wr),
        .commit    (commit),
        .busy      (busy),
        .page_err  (page_err),
        .por_ok    (por_ok)
    );

    // Behavioural array: erased at reset, loaded bytes written at commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                mem[i] <= '1;
            end
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (vmask[i]) begin
                    mem[{store_page, OFF_W'(i)}] <= pdata[i];
                end
            end
        end
    end

    // Combinational read of the array at the low address bits.
    assign dout = mem[addr[STORE_W-1:0]];

endmodule

// File: rtl/pgwr_chk.sv
// Module: pgwr_chk
// Checker bound into pgwr_ctrl. It keeps its own cycle counters and compares
// the sequencer's observable timing against them.
// Assumes: synchronous active-low reset shared with the design.
module pgwr_chk #(
    parameter int OFF_W    = 7,
    parameter int GAP_CYC  = 64,
    parameter int PROG_CYC = 200,
    parameter int POR_CYC  = 40
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  page_err,
    input logic                  buf_start,
    input logic                  buf_wr,
    input logic [(1<<OFF_W)-1:0] vmask
);
    localparam int M1   = (GAP_CYC > PROG_CYC) ? GAP_CYC : PROG_CYC;
    localparam int MX   = (M1 > POR_CYC) ? M1 : POR_CYC;
    localparam int CW   = $clog2(MX + 2);
    localparam int CMAX = MX + 1;

    logic [CW-1:0] busy_len;   // cycles busy has been high
    logic [CW-1:0] since_byte; // cycles since the last accepted byte
    logic [CW-1:0] since_rst;  // cycles since reset release

    // Independent counters for window lengths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len   <= '0;
            since_byte <= '0;
            since_rst  <= '0;
        end else begin
            busy_len <= busy ? ((busy_len == CW'(CMAX)) ? busy_len : busy_len + 1'b1) : '0;
            if (buf_start || buf_wr) begin
                since_byte <= '0;
            end else if (since_byte != CW'(CMAX)) begin
                since_byte <= since_byte + 1'b1;
            end
            if (since_rst != CW'(CMAX)) begin
                since_rst <= since_rst + 1'b1;
            end
        end
    end

    // R5: no load period opens during the power-up hold-off.
    assert_por_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < CW'(POR_CYC)) |-> !buf_start);

    // R7: the error flag holds until a new load period opens.
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (page_err && !buf_start) |=> page_err);

    // R7: opening a load period clears the error flag.
    assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_start |=> !page_err);

    // R8: programming starts exactly GAP_CYC cycles after the last byte.
    assert_gap_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (since_byte == CW'(GAP_CYC)));

    // R9: busy lasts exactly PROG_CYC cycles.
    assert_prog_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == CW'(PROG_CYC)));

    // R11: the loaded mask is frozen while programming.
    assert_mask_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(vmask));

endmodule

bind pgwr_ctrl pgwr_chk #(
    .OFF_W    (OFF_W),
    .GAP_CYC  (GAP_CYC),
    .PROG_CYC (PROG_CYC),
    .POR_CYC  (POR_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .page_err  (page_err),
    .buf_start (buf_start),
    .buf_wr    (buf_wr),
    .vmask     (vmask)
);

// File: tb/tb_pgwr_ctrl.sv
module tb_pgwr_ctrl;
    localparam int ADDR_W = 17, OFF_W = 7, STORE_W = 10;
    localparam int GAP_CYC = 64, PROG_CYC = 200, POR_CYC = 40, GLITCH_CYC = 3;
    localparam int MEM_BYTES = 1 << STORE_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, re_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic busy, page_err;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    // Reference model: array image and pending load period.
    logic [7:0] ref_mem [MEM_BYTES];
    bit         lb_val [128];
    logic [7:0] lb_dat [128];
    logic [9:0] lb_page;
    bit         lb_open = 1'b0;
    bit         lb_err = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pgwr_ctrl #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .STORE_W(STORE_W), .GAP_CYC(GAP_CYC),
        .PROG_CYC(PROG_CYC), .POR_CYC(POR_CYC), .GLITCH_CYC(GLITCH_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .re_n(re_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .busy(busy), .page_err(page_err)
    );

    function automatic logic [ADDR_W-1:0] mk_addr(input logic [9:0] pg, input int off);
        return {pg, 7'(off)};
    endfunction

    function automatic int ref_idx(input logic [ADDR_W-1:0] a);
        return int'(a[STORE_W-1:0]);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = dout;
    endtask

    // Whole-page compare against the model, counted as one check.
    task automatic chk_page(input string req, input logic [9:0] pg);
        int bad = -1;
        logic [7:0] got = '0, want = '0;
        for (int o = 0; o < 128; o++) begin
            logic [7:0] d;
            rd(mk_addr(pg, o), d);
            if (d !== ref_mem[ref_idx(mk_addr(pg, o))] && bad < 0) begin
                bad = o; got = d; want = ref_mem[ref_idx(mk_addr(pg, o))];
            end
        end
        n_chk++;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s page %0h offset %0d actual=%0h expected=%0h", req, pg, bad, got, want);
        end
    endtask

    // One strobe write. mode 0: both strobes together, 1: write-strobe pulse,
    // 2: chip-select pulse. w is the active width in cycles.
    task automatic wr_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int w, input int mode);
        addr = a; din = d;
        cyc(1);
        case (mode)
            1: begin cs_n = 0; cyc(2); we_n = 0; cyc(w); we_n = 1; cyc(1); cs_n = 1; end
            2: begin we_n = 0; cyc(2); cs_n = 0; cyc(w); cs_n = 1; cyc(1); we_n = 1; end
            default: begin cs_n = 0; we_n = 0; cyc(w); cs_n = 1; we_n = 1; end
        endcase
        cyc(4);
    endtask

    // Strobe write plus model update for an accepted byte.
    task automatic wr_load(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int w, input int mode);
        wr_byte(a, d, w, mode);
        if (!lb_open) begin
            lb_open = 1; lb_page = a[16:7]; lb_err = 0;
            for (int i = 0; i < 128; i++) lb_val[i] = 0;
        end
        if (a[16:7] == lb_page) begin
            lb_val[a[6:0]] = 1; lb_dat[a[6:0]] = d;
        end else begin
            lb_err = 1;
        end
    endtask

    task automatic model_commit();
        for (int i = 0; i < 128; i++)
            if (lb_val[i]) ref_mem[ref_idx(mk_addr(lb_page, i))] = lb_dat[i];
        lb_open = 0;
    endtask

    // Wait for programming; check that it starts and how long busy lasts.
    task automatic wait_prog(input string req);
        int t = 0, len = 0;
        while (!busy && t < GAP_CYC + 40) begin cyc(1); t++; end
        chk({req, " busy rises"}, busy, 1);
        while (busy && len < PROG_CYC + 40) begin cyc(1); len++; end
        chk("R9 busy length", len, PROG_CYC);
        model_commit();
    endtask

    // Confirm no programming starts within a full window.
    task automatic no_prog(input string req);
        bit seen = 0;
        for (int t = 0; t < GAP_CYC + 40; t++) begin
            cyc(1);
            if (busy) seen = 1;
        end
        chk({req, " no busy"}, seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd7311));
        for (int i = 0; i < MEM_BYTES; i++) ref_mem[i] = 8'hFF;
        cyc(5);
        rst_n = 1;

        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 page_err", page_err, 0);
        rd(17'h00000, d); chk("R1 array low", d, 8'hFF);
        rd(17'h003FF, d); chk("R1 array high", d, 8'hFF);

        // R5: write inside power-up hold-off is dropped
        wr_byte(17'h00012, 8'h5A, 5, 0);
        no_prog("R5");
        rd(17'h00012, d); chk("R5 byte unchanged", d, 8'hFF);

        // R6 R10 R8: mixed modes, overwrite, gap timing, partial page
        wr_load(mk_addr(10'h005, 3), 8'h11, 4, 0);
        wr_load(mk_addr(10'h005, 100), 8'h22, 4, 1);
        wr_load(mk_addr(10'h005, 3), 8'h33, 4, 2);
        cyc(GAP_CYC - 8);
        chk("R8 busy still low before gap", busy, 0);
        wait_prog("R8");
        chk_page("R10 partial page with overwrite", 10'h005);
        rd(mk_addr(10'h005, 3), d); chk("R10 last value wins", d, 8'h33);

        // R12: upper bits alias onto the stored array
        rd(mk_addr(10'h0AD, 100), d); chk("R12 alias read", d, 8'h22);

        // R4: glitch discarded, minimum width accepted
        wr_byte(mk_addr(10'h006, 9), 8'hA5, GLITCH_CYC - 1, 0);
        no_prog("R4 glitch");
        rd(mk_addr(10'h006, 9), d); chk("R4 glitch byte", d, 8'hFF);
        wr_load(mk_addr(10'h006, 9), 8'h5C, GLITCH_CYC, 0);
        wait_prog("R4 minimum width");
        chk_page("R4 minimum width page", 10'h006);

        // R2: re_n held low blocks, re_n falling mid-phase aborts
        re_n = 0;
        wr_byte(mk_addr(10'h004, 1), 8'h77, 5, 0);
        re_n = 1;
        no_prog("R2 re held low");
        addr = mk_addr(10'h004, 2); din = 8'h78;
        cyc(1); cs_n = 0; we_n = 0; cyc(5); re_n = 0; cyc(2);
        cs_n = 1; we_n = 1; cyc(3); re_n = 1; cyc(4);
        no_prog("R2 re abort");
        chk_page("R2 page untouched", 10'h004);

        // R3: address at later fall, data at earlier rise
        addr = mk_addr(10'h003, 10); din = 8'h11;
        cyc(1); we_n = 0; cyc(3);
        addr = mk_addr(10'h003, 20); cyc(3);
        cs_n = 0; cyc(4);
        addr = mk_addr(10'h003, 30); din = 8'h77; cyc(2);
        cs_n = 1; cyc(4);
        din = 8'h99; we_n = 1; cyc(4);
        lb_open = 1; lb_page = 10'h003; lb_err = 0;
        for (int i = 0; i < 128; i++) lb_val[i] = 0;
        lb_val[20] = 1; lb_dat[20] = 8'h77;
        wait_prog("R3");
        chk_page("R3 capture points", 10'h003);

        // R11: write during programming is ignored
        wr_load(mk_addr(10'h001, 7), 8'h44, 4, 0);
        while (!busy) cyc(1);
        wr_byte(mk_addr(10'h002, 7), 8'hEE, 4, 0);
        wr_byte(mk_addr(10'h001, 8), 8'hEF, 4, 0);
        while (busy) cyc(1);
        model_commit();
        no_prog("R11 no restart");
        chk_page("R11 other page untouched", 10'h002);
        chk_page("R11 same page extra byte dropped", 10'h001);

        // R7: off-page byte dropped, flag sticky, cleared by next load
        wr_load(mk_addr(10'h020, 1), 8'h61, 4, 0);
        wr_load(mk_addr(10'h021, 2), 8'h62, 4, 0);
        chk("R7 flag set", page_err, 1);
        wait_prog("R7");
        chk("R7 flag held after programming", page_err, 1);
        chk_page("R7 dropped byte", 10'h021);
        wr_load(mk_addr(10'h022, 5), 8'h63, 4, 0);
        chk("R7 flag cleared by new load", page_err, 0);
        wait_prog("R7 next load");

        // R8: byte exactly at window end is accepted, one cycle later is not
        wr_load(mk_addr(10'h030, 0), 8'hC0, 4, 0);
        cyc(GAP_CYC - 9);
        wr_load(mk_addr(10'h030, 1), 8'hC1, 4, 0);
        wait_prog("R8 window edge");
        chk_page("R8 byte at window end kept", 10'h030);
        wr_load(mk_addr(10'h031, 0), 8'hD0, 4, 0);
        cyc(GAP_CYC - 8);
        wr_byte(mk_addr(10'h031, 1), 8'hD1, 4, 0);
        while (busy) cyc(1);
        model_commit();
        chk_page("R8 byte after window dropped", 10'h031);

        // R10: full page in descending order
        for (int o = 127; o >= 0; o--) wr_load(mk_addr(10'h009, o), 8'(o) ^ 8'hC3, 3, o % 3);
        wait_prog("R10 full page");
        chk_page("R10 full page", 10'h009);

        // Random load periods
        for (int r = 0; r < 20; r++) begin
            logic [9:0] pg = 10'($urandom_range(0, 1023));
            int n = $urandom_range(1, 10);
            int bad = ($urandom_range(0, 3) == 0) ? $urandom_range(1, n) : 0;
            for (int k = 0; k < n; k++) begin
                logic [9:0] p = (k == bad && bad != 0) ? pg + 10'd1 : pg;
                wr_load(mk_addr(p, $urandom_range(0, 127)), 8'($urandom),
                        $urandom_range(GLITCH_CYC, 6), $urandom_range(0, 2));
            end
            chk("R7 random flag", page_err, lb_err);
            wait_prog("R9 random");
            chk_page("R10 random page", pg);
            if (bad != 0) chk_page("R7 random dropped", pg + 10'd1);
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule